// File: doc/BRIEF.md
# Indexed Colour Palette Converter

This block holds a 256-entry colour table and turns 8-bit pixel indices into packed colour words. A bus master programs the table through a small register window of 32-bit writes. One register selects which table entry is being edited. A second register takes the three colour components of that entry one write at a time, in the order red, green, blue. A short internal phase counter tracks which component comes next. Reads of the window are accepted but always return zero.

On the pixel side, an index comes in with a valid strobe and a format code. One clock later the looked-up colour comes out, packed for the chosen format, together with the number of component-wide lanes that carry data. The 8-bit format does not use the table at all: the index itself goes out. Frame storage, display timing and analog conversion are handled by other blocks.

Top module: `pal_dac`

## Requirements
- R1: The register is chosen by address bits [3:2] alone. Code 0 is the entry-select register and code 1 is the component register. Address bits [1:0] and all bits above bit 3 are ignored. A write with code 2 or 3 changes neither the table, the selected entry nor the component phase.
- R2: A write to the entry-select register loads the selected entry from write-data bits [31:24] and returns the component phase to red.
- R3: Writes to the component register store write-data bits [31:24] into the selected entry's red, then green, then blue component. The phase advances after red and after green.
- R4: After the blue write the phase is red again and the selected entry is unchanged, so a further triple of writes rewrites the same entry.
- R5: After reset, entries 0 to 254 are all-zero in every component, entry 255 is all-ones in every component, and the selected entry and the phase are both zero.
- R6: bus_rdata is zero for every read, whatever the address and whatever the table holds.
- R7: Format code 2'b10 (wide) gives {pad 8'h00, red, green, blue}. Blue is in bits [7:0], green in [15:8], red in [23:16] and the zero pad in [31:24]. pix_lanes_o is 4.
- R8: Format code 2'b01 (packed) gives blue in [7:0], green in [15:8] and red in [23:16], with bits [31:24] zero. pix_lanes_o is 3.
- R9: Format codes 2'b00 and 2'b11 (index) put the input index unchanged in bits [7:0] and zero in the upper bits, with no table lookup. pix_lanes_o is 1.
- R10: pix_valid_o equals pix_valid_i of the previous cycle. Data, lanes and valid all change at the same edge, so back-to-back lookups give one result per cycle.
- R11: When a component write and a lookup of the same entry happen in the same cycle, the lookup returns the value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W (8) | Byte address; only bits [3:2] are decoded |
| bus_wdata | input | DATA_W (32) | Write data; the value is taken from the top byte |
| bus_rdata | output | DATA_W (32) | Read data, always zero |
| pix_valid_i | input | 1 | Lookup request strobe |
| pix_idx_i | input | IDX_W (8) | Pixel index to look up |
| pix_fmt_i | input | 2 | Output format code |
| pix_valid_o | output | 1 | Result strobe, one cycle after the request |
| pix_data_o | output | OUT_W (32) | Packed pixel word |
| pix_lanes_o | output | 3 | Number of lanes of pix_data_o that carry data |

## Verification
A register write changes the table on the clock edge that captures it. Its effect can be seen in a lookup whose request is presented in any later cycle. A pixel result appears exactly one edge after its request. The bench drives inputs on the falling edge and reads the outputs one nanosecond after the next rising edge, which is the edge where the result is due. The write-and-lookup collision is presented within a single cycle, and the result is checked against the component value from before the write. An idle cycle after a burst of lookups checks that the valid strobe falls exactly one cycle later.

// File: rtl/pal_pkg.sv
package pal_pkg;

   // Output format codes decoded on the pixel side
   typedef enum logic [1:0] {
      FMT_IDX8    = 2'b00,
      FMT_RGB24   = 2'b01,
      FMT_RGB32   = 2'b10,
      FMT_IDX8_B  = 2'b11
   } pix_fmt_e;

   // Component phase of the data register
   typedef enum logic [1:0] {
      PH_RED = 2'd0,
      PH_GRN = 2'd1,
      PH_BLU = 2'd2,
      PH_BAD = 2'd3
   } comp_ph_e;

   // Register select codes (address bits [3:2])
   localparam logic [1:0] SEL_INDEX = 2'd0;
   localparam logic [1:0] SEL_COMP  = 2'd1;

   localparam int unsigned SEL_LSB  = 2;
   localparam int unsigned NUM_COMP = 3;
   localparam int unsigned LANES_W  = 3;

endpackage

// File: rtl/pal_wr_seq.sv
module pal_wr_seq
   import pal_pkg::*;
#(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned IDX_W  = 8,
   parameter int unsigned COMP_W = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       bus_we,
   input  logic [ADDR_W-1:0]          bus_addr,
   input  logic [DATA_W-1:0]          bus_wdata,
   output logic [IDX_W-1:0]           cur_idx,
   output comp_ph_e                   phase,
   output logic [NUM_COMP-1:0]        comp_we,
   output logic [COMP_W-1:0]          comp_val
);

   localparam int unsigned VAL_MSB = DATA_W - 1;

   logic [1:0]       sel;
   logic             hit_index;
   logic             hit_comp;
   logic [IDX_W-1:0] new_idx;

   if (ADDR_W < SEL_LSB + 2) begin : g_bad_addr
      $error("pal_wr_seq: ADDR_W too small for the register window");
   end
   if (DATA_W < COMP_W || DATA_W < IDX_W) begin : g_bad_data
      $error("pal_wr_seq: DATA_W narrower than a value field");
   end

   assign sel       = bus_addr[SEL_LSB +: 2];
   assign hit_index = bus_we && (sel == SEL_INDEX);
   assign hit_comp  = bus_we && (sel == SEL_COMP);
   assign new_idx   = bus_wdata[VAL_MSB -: IDX_W];
   assign comp_val  = bus_wdata[VAL_MSB -: COMP_W];

   // Which component array takes the write this cycle
   always_comb begin
      comp_we = '0;
      if (hit_comp) begin
         unique case (phase)
            PH_RED:  comp_we = 3'b001;
            PH_GRN:  comp_we = 3'b010;
            PH_BLU:  comp_we = 3'b100;
            default: comp_we = 3'b000;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_idx <= '0;
         phase   <= PH_RED;
      end else if (hit_index) begin
         cur_idx <= new_idx;
         phase   <= PH_RED;
      end else if (hit_comp) begin
         unique case (phase)
            PH_RED:  phase <= PH_GRN;
            PH_GRN:  phase <= PH_BLU;
            default: phase <= PH_RED;
         endcase
      end
   end

   logic unused_wr_bits;
   assign unused_wr_bits = ^{bus_addr, bus_wdata};

endmodule

// File: rtl/pal_store.sv
module pal_store
   import pal_pkg::*;
#(
   parameter int unsigned IDX_W  = 8,
   parameter int unsigned COMP_W = 8
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [NUM_COMP-1:0]               comp_we,
   input  logic [IDX_W-1:0]                  wr_idx,
   input  logic [COMP_W-1:0]                 wr_val,
   input  logic                              rd_en,
   input  logic [IDX_W-1:0]                  rd_idx,
   output logic [NUM_COMP-1:0][COMP_W-1:0]   rd_comp
);

   localparam int unsigned DEPTH   = 1 << IDX_W;
   localparam int unsigned TOP_IDX = DEPTH - 1;

   if (IDX_W < 1 || IDX_W > 10) begin : g_bad_depth
      $error("pal_store: IDX_W out of supported range");
   end

   // One array per component: 0 red, 1 green, 2 blue
   for (genvar c = 0; c < NUM_COMP; c++) begin : g_comp
      logic [COMP_W-1:0] mem [DEPTH];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
               mem[i] <= (i == TOP_IDX) ? '1 : '0;
            end
         end else if (comp_we[c]) begin
            mem[wr_idx] <= wr_val;
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rd_comp[c] <= '0;
         end else if (rd_en) begin
            rd_comp[c] <= mem[rd_idx];
         end
      end
   end

endmodule

// File: rtl/pal_pack.sv
module pal_pack
   import pal_pkg::*;
#(
   parameter int unsigned IDX_W   = 8,
   parameter int unsigned COMP_W  = 8,
   parameter int unsigned OUT_W   = 32,
   parameter logic [7:0]  PAD_VAL = 8'h00
) (
   input  pix_fmt_e                          fmt,
   input  logic [IDX_W-1:0]                  idx,
   input  logic [NUM_COMP-1:0][COMP_W-1:0]   comp,
   output logic [OUT_W-1:0]                  word,
   output logic [LANES_W-1:0]                lanes
);

   localparam int unsigned RGB_W = NUM_COMP * COMP_W;
   localparam int unsigned WIDE_W = RGB_W + COMP_W;

   if (OUT_W < WIDE_W) begin : g_bad_out
      $error("pal_pack: OUT_W cannot hold a padded pixel");
   end
   if (IDX_W > COMP_W) begin : g_bad_idx
      $error("pal_pack: index wider than one lane");
   end

   logic [COMP_W-1:0] pad_lane;
   logic [COMP_W-1:0] idx_lane;

   // The pad value is given as a byte; fit it to the lane width
   if (COMP_W >= 8) begin : g_pad_wide
      assign pad_lane = COMP_W'(PAD_VAL);
   end else begin : g_pad_narrow
      assign pad_lane = PAD_VAL[COMP_W-1:0];
   end

   if (IDX_W == COMP_W) begin : g_idx_full
      assign idx_lane = idx;
   end else begin : g_idx_ext
      assign idx_lane = {{(COMP_W-IDX_W){1'b0}}, idx};
   end

   always_comb begin
      word  = '0;
      lanes = LANES_W'(1);
      unique case (fmt)
         FMT_RGB32: begin
            word[WIDE_W-1:0] = {pad_lane, comp[0], comp[1], comp[2]};
            lanes            = LANES_W'(4);
         end
         FMT_RGB24: begin
            word[RGB_W-1:0]  = {comp[0], comp[1], comp[2]};
            lanes            = LANES_W'(3);
         end
         default: begin
            word[COMP_W-1:0] = idx_lane;
            lanes            = LANES_W'(1);
         end
      endcase
   end

endmodule

// File: rtl/pal_dac.sv
module pal_dac
   import pal_pkg::*;
#(
   parameter int unsigned ADDR_W  = 8,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned IDX_W   = 8,
   parameter int unsigned COMP_W  = 8,
   parameter int unsigned OUT_W   = 32,
   parameter logic [7:0]  PAD_VAL = 8'h00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic              bus_re,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              pix_valid_i,
   input  logic [IDX_W-1:0]  pix_idx_i,
   input  logic [1:0]        pix_fmt_i,
   output logic              pix_valid_o,
   output logic [OUT_W-1:0]  pix_data_o,
   output logic [2:0]        pix_lanes_o
);

   logic [IDX_W-1:0]                 cur_idx;
   comp_ph_e                         phase;
   logic [NUM_COMP-1:0]              comp_we;
   logic [COMP_W-1:0]                comp_val;
   logic [NUM_COMP-1:0][COMP_W-1:0]  rd_comp;

   logic             v_q;
   logic [IDX_W-1:0] idx_q;
   pix_fmt_e         fmt_q;

   // The register window holds no readable state
   assign bus_rdata = '0;

   pal_wr_seq #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .IDX_W  (IDX_W),
      .COMP_W (COMP_W)
   ) seq_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .cur_idx   (cur_idx),
      .phase     (phase),
      .comp_we   (comp_we),
      .comp_val  (comp_val)
   );

   pal_store #(
      .IDX_W  (IDX_W),
      .COMP_W (COMP_W)
   ) store_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .comp_we (comp_we),
      .wr_idx  (cur_idx),
      .wr_val  (comp_val),
      .rd_en   (pix_valid_i),
      .rd_idx  (pix_idx_i),
      .rd_comp (rd_comp)
   );

   // Side-band stage carried alongside the table read
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_q   <= 1'b0;
         idx_q <= '0;
         fmt_q <= FMT_IDX8;
      end else begin
         v_q <= pix_valid_i;
         if (pix_valid_i) begin
            idx_q <= pix_idx_i;
            fmt_q <= pix_fmt_e'(pix_fmt_i);
         end
      end
   end

   pal_pack #(
      .IDX_W   (IDX_W),
      .COMP_W  (COMP_W),
      .OUT_W   (OUT_W),
      .PAD_VAL (PAD_VAL)
   ) pack_i (
      .fmt   (fmt_q),
      .idx   (idx_q),
      .comp  (rd_comp),
      .word  (pix_data_o),
      .lanes (pix_lanes_o)
   );

   assign pix_valid_o = v_q;

   logic unused_top;
   assign unused_top = bus_re;

endmodule

// File: rtl/pal_dac_chk.sv
module pal_dac_chk #(
   parameter int unsigned ADDR_W  = 8,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned IDX_W   = 8,
   parameter int unsigned COMP_W  = 8,
   parameter int unsigned OUT_W   = 32,
   parameter logic [7:0]  PAD_VAL = 8'h00
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              pix_valid_i,
   input logic [IDX_W-1:0]  pix_idx_i,
   input logic [1:0]        pix_fmt_i,
   input logic              pix_valid_o,
   input logic [OUT_W-1:0]  pix_data_o,
   input logic [2:0]        pix_lanes_o,
   input logic [IDX_W-1:0]  cur_idx,
   input logic [1:0]        phase
);

   logic [1:0] csel;
   assign csel = bus_addr[3:2];

   logic unused_chk;
   assign unused_chk = ^{bus_addr, bus_wdata};

   assert_ignored_sel_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && csel[1]) |=> ($stable(phase) && $stable(cur_idx)));

   assert_index_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && csel == 2'd0) |=>
         (cur_idx == $past(bus_wdata[DATA_W-1 -: IDX_W]) && phase == 2'd0));

   assert_red_to_green_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && csel == 2'd1 && phase == 2'd0) |=> (phase == 2'd1));

   assert_green_to_blue_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && csel == 2'd1 && phase == 2'd1) |=> (phase == 2'd2));

   assert_phase_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
      phase != 2'd3);

   assert_blue_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && csel == 2'd1 && phase == 2'd2) |=>
         (phase == 2'd0 && $stable(cur_idx)));

   assert_wide_fmt_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid_i && pix_fmt_i == 2'b10) |=>
         (pix_lanes_o == 3'd4 && pix_data_o[4*COMP_W-1 -: COMP_W] == COMP_W'(PAD_VAL)));

   assert_packed_fmt_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid_i && pix_fmt_i == 2'b01) |=>
         (pix_lanes_o == 3'd3 && pix_data_o[OUT_W-1:3*COMP_W] == '0));

   assert_index_fmt_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid_i && (pix_fmt_i == 2'b00 || pix_fmt_i == 2'b11)) |=>
         (pix_lanes_o == 3'd1 &&
          pix_data_o == OUT_W'($past(pix_idx_i))));

   assert_valid_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid_i |=> pix_valid_o);

   assert_valid_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_valid_i |=> !pix_valid_o);

endmodule

bind pal_dac pal_dac_chk #(
   .ADDR_W  (ADDR_W),
   .DATA_W  (DATA_W),
   .IDX_W   (IDX_W),
   .COMP_W  (COMP_W),
   .OUT_W   (OUT_W),
   .PAD_VAL (PAD_VAL)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_we      (bus_we),
   .bus_addr    (bus_addr),
   .bus_wdata   (bus_wdata),
   .pix_valid_i (pix_valid_i),
   .pix_idx_i   (pix_idx_i),
   .pix_fmt_i   (pix_fmt_i),
   .pix_valid_o (pix_valid_o),
   .pix_data_o  (pix_data_o),
   .pix_lanes_o (pix_lanes_o),
   .cur_idx     (cur_idx),
   .phase       (phase)
);

// File: tb/pal_dac_tb_top.sv
`timescale 1ns/1ps
module pal_dac_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic        bus_re = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        pix_valid_i = 1'b0;
   logic [7:0]  pix_idx_i = '0;
   logic [1:0]  pix_fmt_i = '0;
   logic        pix_valid_o;
   logic [31:0] pix_data_o;
   logic [2:0]  pix_lanes_o;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // Reference table and register state
   logic [7:0] m_r [256];
   logic [7:0] m_g [256];
   logic [7:0] m_b [256];
   logic [7:0] m_idx;
   int         m_ph;

   always #4 clk = ~clk;

   pal_dac dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_we      (bus_we),
      .bus_re      (bus_re),
      .bus_addr    (bus_addr),
      .bus_wdata   (bus_wdata),
      .bus_rdata   (bus_rdata),
      .pix_valid_i (pix_valid_i),
      .pix_idx_i   (pix_idx_i),
      .pix_fmt_i   (pix_fmt_i),
      .pix_valid_o (pix_valid_o),
      .pix_data_o  (pix_data_o),
      .pix_lanes_o (pix_lanes_o)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_word(input logic [7:0] i, input logic [1:0] f);
      case (f)
         2'b10:   return {8'h00, m_r[i], m_g[i], m_b[i]};
         2'b01:   return {8'h00, m_r[i], m_g[i], m_b[i]};
         default: return {24'h0, i};
      endcase
   endfunction

   function automatic logic [31:0] exp_lanes(input logic [1:0] f);
      case (f)
         2'b10:   return 32'd4;
         2'b01:   return 32'd3;
         default: return 32'd1;
      endcase
   endfunction

   function automatic string fmt_req(input logic [1:0] f);
      case (f)
         2'b10:   return "R7";
         2'b01:   return "R8";
         default: return "R9";
      endcase
   endfunction

   // Apply the register rules to the reference state
   function automatic void model_wr(input logic [7:0] a, input logic [31:0] d);
      case (a[3:2])
         2'd0: begin m_idx = d[31:24]; m_ph = 0; end
         2'd1: begin
            case (m_ph)
               0: begin m_r[m_idx] = d[31:24]; m_ph = 1; end
               1: begin m_g[m_idx] = d[31:24]; m_ph = 2; end
               default: begin m_b[m_idx] = d[31:24]; m_ph = 0; end
            endcase
         end
         default: ;
      endcase
   endfunction

   task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      #1;
      bus_we = 1'b0;
      model_wr(a, d);
   endtask

   task automatic lookup(input logic [7:0] i, input logic [1:0] f, input string tag);
      @(negedge clk);
      pix_valid_i = 1'b1; pix_idx_i = i; pix_fmt_i = f;
      @(posedge clk);
      #1;
      check({tag, " ", fmt_req(f), " data"}, pix_data_o, exp_word(i, f));
      check({tag, " ", fmt_req(f), " lanes"}, {29'h0, pix_lanes_o}, exp_lanes(f));
      check({tag, " R10 valid"}, {31'h0, pix_valid_o}, 32'd1);
      pix_valid_i = 1'b0;
   endtask

   task automatic set_entry(input logic [7:0] i, input logic [7:0] r,
                            input logic [7:0] g, input logic [7:0] b);
      bus_wr(8'h00, {i, 24'h0});
      bus_wr(8'h04, {r, 24'h0});
      bus_wr(8'h04, {g, 24'h0});
      bus_wr(8'h04, {b, 24'h0});
   endtask

   initial begin
      for (int i = 0; i < 256; i++) begin
         m_r[i] = (i == 255) ? 8'hFF : 8'h00;
         m_g[i] = (i == 255) ? 8'hFF : 8'h00;
         m_b[i] = (i == 255) ? 8'hFF : 8'h00;
      end
      m_idx = 8'h00;
      m_ph  = 0;

      repeat (3) @(posedge clk);
      #1;
      check("R5 valid in reset", {31'h0, pix_valid_o}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      check("R5 valid after reset", {31'h0, pix_valid_o}, 32'd0);

      // R5: whole table after reset, wide format
      for (int i = 0; i < 256; i++) lookup(8'(i), 2'b10, "R5 reset table");

      // R5: phase and index are zero after reset, so components go to entry 0 from red
      bus_wr(8'h04, 32'h1100_0000);
      bus_wr(8'h04, 32'h2200_0000);
      bus_wr(8'h04, 32'h3300_0000);
      lookup(8'h00, 2'b10, "R5 start state");

      // R1/R3: fill the table with aliased addresses and ignored writes mixed in
      for (int i = 0; i < 256; i++) begin
         logic [7:0] hi;
         logic [7:0] dsel;
         hi   = 8'((i % 16) << 4);
         dsel = hi | 8'h04 | 8'(i % 4);
         bus_wr(hi | 8'(i % 4), {8'(i), 24'h00_1234});
         bus_wr(dsel, {8'(i) ^ 8'h5A, 24'hABCDEF});
         if (i % 3 == 0) bus_wr(hi | 8'h08, 32'hDEAD_BEEF);
         bus_wr(dsel, {8'(i * 7 + 3), 24'h0});
         if (i % 5 == 0) bus_wr(hi | 8'h0C, 32'hC0DE_0000);
         bus_wr(dsel, {~8'(i), 24'h0});
      end

      // R3/R7/R8/R9: full sweep in every format code
      for (int f = 0; f < 4; f++)
         for (int i = 0; i < 256; i++)
            lookup(8'(i), 2'(f), "R3 sweep");

      // R1: ignored offsets between index select and first component
      bus_wr(8'h00, 32'h4000_0000);
      bus_wr(8'h08, 32'h9900_0000);
      bus_wr(8'h0C, 32'h8800_0000);
      bus_wr(8'h04, 32'h0100_0000);
      bus_wr(8'h0B, 32'h7700_0000);
      bus_wr(8'h04, 32'h0200_0000);
      bus_wr(8'h04, 32'h0300_0000);
      lookup(8'h40, 2'b10, "R1 ignored offsets");
      lookup(8'h99, 2'b10, "R1 untouched entry");

      // R4: second triple without a new index lands on the same entry
      set_entry(8'h0A, 8'h10, 8'h20, 8'h30);
      bus_wr(8'h04, 32'hA100_0000);
      bus_wr(8'h04, 32'hA200_0000);
      bus_wr(8'h04, 32'hA300_0000);
      lookup(8'h0A, 2'b01, "R4 rewrite");
      lookup(8'h0B, 2'b01, "R4 neighbour");

      // R2: reselecting the index restarts at red
      bus_wr(8'h00, 32'h1400_0000);
      bus_wr(8'h04, 32'h5500_0000);
      bus_wr(8'h04, 32'h6600_0000);
      bus_wr(8'h00, 32'h1400_0000);
      bus_wr(8'h04, 32'h7700_0000);
      bus_wr(8'h04, 32'h8800_0000);
      bus_wr(8'h04, 32'h9900_0000);
      lookup(8'h14, 2'b10, "R2 phase clear");
      bus_wr(8'h00, 32'hFF00_0000);
      bus_wr(8'h04, 32'h0000_0000);
      lookup(8'hFF, 2'b10, "R2 top entry red only");

      // R6: reads anywhere return zero
      for (int a = 0; a < 16; a++) begin
         @(negedge clk);
         bus_re = 1'b1; bus_addr = 8'(a * 17);
         #1;
         check("R6 read data", bus_rdata, 32'h0);
      end
      @(negedge clk);
      bus_re = 1'b0;

      // R10: back-to-back stream, then valid falls one cycle later
      for (int k = 0; k < 20; k++) begin
         @(negedge clk);
         pix_valid_i = 1'b1; pix_idx_i = 8'(k * 13); pix_fmt_i = 2'(k % 4);
         @(posedge clk);
         #1;
         check({"R10 stream ", fmt_req(2'(k % 4))}, pix_data_o, exp_word(8'(k * 13), 2'(k % 4)));
         check("R10 stream valid", {31'h0, pix_valid_o}, 32'd1);
      end
      @(negedge clk);
      pix_valid_i = 1'b0;
      pix_idx_i = 8'h00;
      @(posedge clk);
      #1;
      check("R10 valid drop", {31'h0, pix_valid_o}, 32'd0);

      // R11: blue write and lookup of the same entry in one cycle
      bus_wr(8'h00, 32'h3C00_0000);
      bus_wr(8'h04, 32'h1200_0000);
      bus_wr(8'h04, 32'h3400_0000);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = 8'h04; bus_wdata = 32'hEE00_0000;
      pix_valid_i = 1'b1; pix_idx_i = 8'h3C; pix_fmt_i = 2'b10;
      @(posedge clk);
      #1;
      check("R11 old value on collision", pix_data_o, exp_word(8'h3C, 2'b10));
      bus_we = 1'b0;
      pix_valid_i = 1'b0;
      model_wr(8'h04, 32'hEE00_0000);
      lookup(8'h3C, 2'b10, "R11 new value after");

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL R10 watchdog: actual %0d cycles expected completion", 200000);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule